// File: doc/BRIEF.md
# Frame Acquisition Mode Controller

This block sequences writes of digitised video into an interlaced frame memory. The host chooses one of four operations by writing a two-bit mode field: freeze, clear, snap or grab. Freeze stops work. Clear zeroes the whole memory once. Snap captures a single frame of two fields. Grab captures frames until the host asks it to stop. The block follows a video sync source through three inputs: field parity, vertical blank and horizontal blank. From these it counts the pixel position and forms the memory address and the write strobe. One host-programmable plane mask guards memory bits during acquisition. A second mask guards them during host writes and clear passes.

On read, the same mode field shows the operation that is still running and returns to zero once the block is idle. The status byte also carries the field parity, a last-field flag, and the two blank flags. The last-field flag and the blank flags read low while their condition holds. The status byte also returns two stored select bits, one for the input channel and one for the clock source, which drive output pins. Digitising the video and separating the sync are done elsewhere.

Top module: `acq_mode_ctrl`

## Requirements
- R1: After reset the block is idle and issues no memory write. Both selects are 0. With both blank inputs high and field parity low, the status byte reads 8'h08.
- R2: The host writes the mode in bits 7:6 of the control register (reg_sel 0): 0 freeze, 1 clear, 2 snap, 3 grab. Reading status bits 7:6 returns the running mode, and 0 once idle.
- R3: Control bit 0 sets chan_sel (1 means channel 1). Control bit 1 sets pll_sel (1 means PLL, 0 means crystal). Both show on their pins and in status bits 0 and 1.
- R4: Snap waits for the start of an odd field, then writes that field and the following even field, then goes idle. The pixel address is {line, field bit, pixel}, where the field bit is 0 for odd and 1 for even.
- R5: Clear writes data 0 once to every one of the 2*LINE_PIX*FIELD_LINES addresses, then goes idle.
- R6: The host mask is written with reg_sel 1. Each set bit stops that plane from changing during host writes and clear writes; mem_bmask bit 1 means the plane is written.
- R7: The video mask is written with reg_sel 2. Each set bit stops that plane from changing during acquire writes.
- R8: Grab writes every field from the first odd field onward. Freeze written during a grab ends acquisition at the end of the current field.
- R9: Pixel writes occur only while both vertical and horizontal blank are inactive.
- R10: While the block is busy, writes of modes 1 to 3 and host pixel writes are dropped. Freeze written while waiting for a frame returns the block to idle at once.
- R11: Status bit 3 reads 0 while the final field is being acquired: the even field of a snap, or a grab field after freeze was written. Otherwise it reads 1.
- R12: Status bit 2 is 1 during an odd field. Bit 4 reads 0 during vertical blank, and bit 5 reads 0 during horizontal blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 host mask, 2 video mask |
| reg_wdata | input | 8 | Register write data |
| status | output | 8 | Mode, blank, field and select status |
| chan_sel | output | 1 | Video input channel select |
| pll_sel | output | 1 | Clock source select |
| vsync_blank | input | 1 | Vertical blank, high while blanking |
| hsync_blank | input | 1 | Horizontal blank, high while blanking |
| field_odd | input | 1 | High during an odd field |
| vid_pix | input | PLANES | Digitised pixel |
| host_we | input | 1 | Host pixel write request |
| host_addr | input | AW | Host pixel address |
| host_wdata | input | PLANES | Host pixel data |
| mem_we | output | 1 | Frame memory write enable |
| mem_addr | output | AW | Frame memory address |
| mem_wdata | output | PLANES | Frame memory write data |
| mem_bmask | output | PLANES | Per-plane write enable, 1 means write |

## Verification
A sequencer stuck in the wrong state shows in status bits 7:6 within the sync latency. It also shows as writes landing where none belong: during a blank, during the wait for an odd field, or after a freeze has taken effect. A wrong pixel or line count, or a wrong field bit, places data at the wrong address. This shows when the frame memory model is compared at the end of each frame. A mask applied to the wrong source changes the stored bit planes at the very next write.

// File: rtl/acq_pkg.sv
package acq_pkg;
   typedef enum logic [1:0] {
      MODE_FREEZE = 2'd0,
      MODE_CLEAR  = 2'd1,
      MODE_SNAP   = 2'd2,
      MODE_GRAB   = 2'd3
   } acq_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CLEAR = 2'd1,
      ST_WAIT  = 2'd2,
      ST_RUN   = 2'd3
   } acq_state_e;

   localparam logic [1:0] SEL_CTRL  = 2'd0;
   localparam logic [1:0] SEL_HMASK = 2'd1;
   localparam logic [1:0] SEL_VMASK = 2'd2;
endpackage

// File: rtl/acq_sync_track.sv
module acq_sync_track #(
   parameter int STAGES = 2,
   parameter int PW     = 8,
   parameter int XW     = 3,
   parameter int YW     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vb_i,
   input  logic          hb_i,
   input  logic          odd_i,
   input  logic [PW-1:0] pix_i,
   output logic          vb,
   output logic          hb,
   output logic          odd,
   output logic [PW-1:0] pix,
   output logic          active,
   output logic          fstart,
   output logic          fend,
   output logic [XW-1:0] x,
   output logic [YW-1:0] y
);
   localparam int SW = PW + 3;
   localparam logic [SW-1:0] RST_V = {2'b11, 1'b0, {PW{1'b0}}};

   logic [SW-1:0] tap;
   logic          vb_prev, hb_prev;

   generate
      if (STAGES == 0) begin : g_direct
         assign tap = {vb_i, hb_i, odd_i, pix_i};
      end else begin : g_chain
         logic [STAGES-1:0][SW-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
            end else begin
               stg[0] <= {vb_i, hb_i, odd_i, pix_i};
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign tap = stg[STAGES-1];
      end
   endgenerate

   assign {vb, hb, odd, pix} = tap;
   assign active = ~vb & ~hb;
   assign fstart = vb_prev & ~vb;
   assign fend   = ~vb_prev & vb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vb_prev <= 1'b1;
         hb_prev <= 1'b1;
         x       <= '0;
         y       <= '0;
      end else begin
         vb_prev <= vb;
         hb_prev <= hb;
         if (hb)          x <= '0;
         else if (active) x <= x + 1'b1;
         if (vb)                y <= '0;
         else if (hb & ~hb_prev) y <= y + 1'b1;
      end
   end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
   import acq_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  acq_mode_e     cfg_mode,
   input  logic          fstart,
   input  logic          fend,
   input  logic          odd,
   output acq_state_e    state,
   output acq_mode_e     run_mode,
   output logic [AW-1:0] clr_addr,
   output logic          last_field,
   output logic [1:0]    busy_code
);
   logic stop_req;
   logic freeze_wr;
   logic stop_now;

   assign freeze_wr = cfg_wr && (cfg_mode == MODE_FREEZE);
   assign stop_now  = stop_req | freeze_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         run_mode <= MODE_FREEZE;
         stop_req <= 1'b0;
         clr_addr <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               stop_req <= 1'b0;
               if (cfg_wr) begin
                  case (cfg_mode)
                     MODE_CLEAR: begin
                        state    <= ST_CLEAR;
                        clr_addr <= '0;
                     end
                     MODE_SNAP, MODE_GRAB: begin
                        state    <= ST_WAIT;
                        run_mode <= cfg_mode;
                     end
                     default: state <= ST_IDLE;
                  endcase
               end
            end
            ST_CLEAR: begin
               if (freeze_wr || (&clr_addr)) state <= ST_IDLE;
               else clr_addr <= clr_addr + 1'b1;
            end
            ST_WAIT: begin
               if (freeze_wr)          state <= ST_IDLE;
               else if (fstart && odd) state <= ST_RUN;
            end
            ST_RUN: begin
               if (freeze_wr) stop_req <= 1'b1;
               if (fend && (stop_now || (run_mode == MODE_SNAP && !odd))) begin
                  state    <= ST_IDLE;
                  stop_req <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign last_field = (state == ST_RUN) &&
                       (stop_req || (run_mode == MODE_SNAP && !odd));

   always_comb begin
      case (state)
         ST_IDLE:  busy_code = 2'd0;
         ST_CLEAR: busy_code = 2'd1;
         default:  busy_code = run_mode;
      endcase
   end
endmodule

// File: rtl/acq_wr_mux.sv
module acq_wr_mux
   import acq_pkg::*;
#(
   parameter int AW = 6,
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  acq_state_e    state,
   input  logic          active,
   input  logic [AW-1:0] pix_addr,
   input  logic [PW-1:0] pix,
   input  logic [AW-1:0] clr_addr,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [PW-1:0] host_wdata,
   input  logic [PW-1:0] host_mask,
   input  logic [PW-1:0] video_mask,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [PW-1:0] mem_wdata,
   output logic [PW-1:0] mem_bmask
);
   logic          we_n;
   logic [AW-1:0] addr_n;
   logic [PW-1:0] data_n, bm_n;

   always_comb begin
      we_n   = 1'b0;
      addr_n = '0;
      data_n = '0;
      bm_n   = '0;
      case (state)
         ST_CLEAR: begin
            we_n   = 1'b1;
            addr_n = clr_addr;
            bm_n   = ~host_mask;
         end
         ST_RUN: begin
            we_n   = active;
            addr_n = pix_addr;
            data_n = pix;
            bm_n   = ~video_mask;
         end
         ST_IDLE: begin
            we_n   = host_we;
            addr_n = host_addr;
            data_n = host_wdata;
            bm_n   = ~host_mask;
         end
         default: we_n = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         mem_bmask <= '0;
      end else begin
         mem_we    <= we_n;
         mem_addr  <= addr_n;
         mem_wdata <= data_n;
         mem_bmask <= bm_n;
      end
   end
endmodule

// File: rtl/acq_mode_ctrl.sv
module acq_mode_ctrl
   import acq_pkg::*;
#(
   parameter int PLANES      = 8,
   parameter int LINE_PIX    = 8,
   parameter int FIELD_LINES = 4,
   parameter int SYNC_STAGES = 2,
   localparam int XW = $clog2(LINE_PIX),
   localparam int YW = $clog2(FIELD_LINES),
   localparam int AW = XW + YW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        status,
   output logic              chan_sel,
   output logic              pll_sel,
   input  logic              vsync_blank,
   input  logic              hsync_blank,
   input  logic              field_odd,
   input  logic [PLANES-1:0] vid_pix,
   input  logic              host_we,
   input  logic [AW-1:0]     host_addr,
   input  logic [PLANES-1:0] host_wdata,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [PLANES-1:0] mem_wdata,
   output logic [PLANES-1:0] mem_bmask
);
   if (PLANES < 1 || PLANES > 8) begin : g_bad_planes
      $error("PLANES must lie in 1..8");
   end
   if ((LINE_PIX < 2) || ((LINE_PIX & (LINE_PIX - 1)) != 0)) begin : g_bad_line
      $error("LINE_PIX must be a power of two of at least 2");
   end
   if ((FIELD_LINES < 2) || ((FIELD_LINES & (FIELD_LINES - 1)) != 0)) begin : g_bad_lines
      $error("FIELD_LINES must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic [PLANES-1:0] host_mask, video_mask;
   logic              vb_s, hb_s, odd_s, active_s, fstart_s, fend_s;
   logic [PLANES-1:0] pix_s;
   logic [XW-1:0]     x_s;
   logic [YW-1:0]     y_s;
   acq_state_e        state_w;
   acq_mode_e         run_mode_w;
   logic [AW-1:0]     clr_addr_w;
   logic              last_w;
   logic [1:0]        busy_w;
   logic              ctrl_wr;

   assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_sel   <= 1'b0;
         pll_sel    <= 1'b0;
         host_mask  <= '0;
         video_mask <= '0;
      end else if (reg_wr) begin
         case (reg_sel)
            SEL_CTRL: begin
               chan_sel <= reg_wdata[0];
               pll_sel  <= reg_wdata[1];
            end
            SEL_HMASK: host_mask  <= reg_wdata[PLANES-1:0];
            SEL_VMASK: video_mask <= reg_wdata[PLANES-1:0];
            default: ;
         endcase
      end
   end

   acq_sync_track #(
      .STAGES(SYNC_STAGES), .PW(PLANES), .XW(XW), .YW(YW)
   ) u_sync (
      .clk(clk), .rst_n(rst_n),
      .vb_i(vsync_blank), .hb_i(hsync_blank), .odd_i(field_odd), .pix_i(vid_pix),
      .vb(vb_s), .hb(hb_s), .odd(odd_s), .pix(pix_s),
      .active(active_s), .fstart(fstart_s), .fend(fend_s),
      .x(x_s), .y(y_s)
   );

   acq_seq #(.AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(ctrl_wr), .cfg_mode(acq_mode_e'(reg_wdata[7:6])),
      .fstart(fstart_s), .fend(fend_s), .odd(odd_s),
      .state(state_w), .run_mode(run_mode_w), .clr_addr(clr_addr_w),
      .last_field(last_w), .busy_code(busy_w)
   );

   acq_wr_mux #(.AW(AW), .PW(PLANES)) u_mux (
      .clk(clk), .rst_n(rst_n),
      .state(state_w), .active(active_s),
      .pix_addr({y_s, ~odd_s, x_s}), .pix(pix_s),
      .clr_addr(clr_addr_w),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_mask(host_mask), .video_mask(video_mask),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_bmask(mem_bmask)
   );

   assign status = {busy_w, ~hb_s, ~vb_s, ~last_w, odd_s, pll_sel, chan_sel};
endmodule

// File: rtl/acq_mode_ctrl_chk.sv
module acq_mode_ctrl_chk
   import acq_pkg::*;
#(
   parameter int PLANES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input acq_state_e        state_w,
   input acq_mode_e         run_mode_w,
   input logic              active_s,
   input logic              odd_s,
   input logic              fend_s,
   input logic [7:0]        status,
   input logic              mem_we,
   input logic [PLANES-1:0] mem_wdata,
   input logic [PLANES-1:0] mem_bmask,
   input logic [PLANES-1:0] host_mask,
   input logic [PLANES-1:0] video_mask
);
   a_r2_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (state_w == ST_IDLE) |-> (status[7:6] == 2'd0));

   a_r5_clear_writes_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (state_w == ST_CLEAR) |=> (mem_we && mem_wdata == '0 && mem_bmask == ~$past(host_mask)));

   a_r7_acq_uses_video_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (state_w == ST_RUN && active_s) |=> (mem_we && mem_bmask == ~$past(video_mask)));

   a_r9_no_write_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (state_w == ST_RUN && !active_s) |=> !mem_we);

   a_r4_snap_ends_after_even: assert property (@(posedge clk) disable iff (!rst_n)
      (state_w == ST_RUN && run_mode_w == MODE_SNAP && fend_s && !odd_s) |=> (state_w == ST_IDLE));

   a_r10_wait_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (state_w == ST_WAIT) |=> !mem_we);
endmodule

bind acq_mode_ctrl acq_mode_ctrl_chk #(.PLANES(PLANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .state_w(state_w), .run_mode_w(run_mode_w),
   .active_s(active_s), .odd_s(odd_s), .fend_s(fend_s), .status(status),
   .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_bmask(mem_bmask),
   .host_mask(host_mask), .video_mask(video_mask)
);

// File: tb/acq_mode_ctrl_tb.sv
`timescale 1ns/1ps
module acq_mode_ctrl_tb;
   localparam int LP = 8;
   localparam int FL = 4;
   localparam int AW = 6;
   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] status;
   logic       chan_sel, pll_sel;
   logic       vsync_blank = 1'b1, hsync_blank = 1'b1, field_odd = 1'b0;
   logic [7:0] vid_pix = 8'd0;
   logic       host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [7:0] host_wdata = 8'd0;
   logic       mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0] mem_wdata, mem_bmask;

   int errors = 0;
   int checks = 0;
   int wr_cnt = 0;
   bit done = 0;
   logic [7:0] mdl [DEPTH];
   logic [7:0] mid_stat;
   logic [7:0] mid_stat2;

   always #4 clk = ~clk;

   acq_mode_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .status(status), .chan_sel(chan_sel), .pll_sel(pll_sel),
      .vsync_blank(vsync_blank), .hsync_blank(hsync_blank), .field_odd(field_odd),
      .vid_pix(vid_pix), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_bmask(mem_bmask)
   );

   always @(posedge clk) begin
      if (rst_n && mem_we) begin
         mdl[mem_addr] <= (mdl[mem_addr] & ~mem_bmask) | (mem_wdata & mem_bmask);
         wr_cnt <= wr_cnt + 1;
      end
   end

   function automatic logic [7:0] pat(input logic [7:0] seed, input bit f, input int y, input int x);
      return seed ^ 8'((f ? 128 : 0) + y * 16 + x);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wreg(input logic [1:0] sel, input logic [7:0] d);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic hwrite(input int a, input logic [7:0] d);
      host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
      tick();
      host_we = 1'b0;
   endtask

   // One field: blank, active lines, then blank again. Samples status mid-field.
   task automatic drive_field(input bit odd, input logic [7:0] seed, input bit freeze_mid);
      vsync_blank = 1'b1; hsync_blank = 1'b1; field_odd = odd;
      tick(4);
      vsync_blank = 1'b0;
      tick(2);
      for (int y = 0; y < FL; y++) begin
         for (int x = 0; x < LP; x++) begin
            hsync_blank = 1'b0;
            vid_pix = pat(seed, odd, y, x);
            if (freeze_mid && y == 1 && x == 2) begin
               reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h03;
            end else begin
               reg_wr = 1'b0;
            end
            if (y == 1 && x == 5) mid_stat = status;
            if (y == 2 && x == 5) mid_stat2 = status;
            tick();
         end
         reg_wr = 1'b0;
         hsync_blank = 1'b1;
         tick(2);
      end
      vsync_blank = 1'b1;
      tick(4);
   endtask

   task automatic t_reset;
      tick(2);
      check("R1 reset status", status, 8'h08);
      check("R1 reset no write", mem_we, 1'b0);
      check("R1 reset selects", {chan_sel, pll_sel}, 2'b00);
   endtask

   task automatic t_selects;
      wreg(2'd0, 8'h01);
      tick(1);
      check("R3 channel select", {pll_sel, chan_sel}, 2'b01);
      wreg(2'd0, 8'h02);
      tick(1);
      check("R3 pll select", {pll_sel, chan_sel}, 2'b10);
      check("R3 status select bits", status[1:0], 2'b10);
      wreg(2'd0, 8'h03);
      tick(1);
      check("R2 freeze while idle reads zero", status[7:6], 2'd0);
   endtask

   task automatic t_clear;
      int n0;
      wreg(2'd1, 8'h00);
      for (int a = 0; a < DEPTH; a++) hwrite(a, 8'hFF);
      tick(3);
      check("R6 host prefill", mdl[17], 8'hFF);
      wreg(2'd1, 8'h0F);
      n0 = wr_cnt;
      wreg(2'd0, 8'h43);
      tick(2);
      check("R2 busy reads clear", status[7:6], 2'd1);
      tick(DEPTH + 4);
      check("R5 clear write count", wr_cnt - n0, DEPTH);
      check("R2 idle after clear", status[7:6], 2'd0);
      for (int a = 0; a < DEPTH; a++) begin
         if (a == 0 || a == 33 || a == DEPTH - 1) check("R6 R5 clear with host mask", mdl[a], 8'h0F);
      end
   endtask

   task automatic t_busy_ignore;
      int n0;
      wreg(2'd1, 8'h00);
      wreg(2'd0, 8'h83);
      tick(1);
      check("R2 snap mode reads back", status[7:6], 2'd2);
      n0 = wr_cnt;
      hwrite(5, 8'hAA);
      wreg(2'd0, 8'h43);
      tick(3);
      check("R10 host write dropped while busy", wr_cnt - n0, 0);
      check("R10 clear ignored while busy", status[7:6], 2'd2);
      wreg(2'd0, 8'h03);
      tick(1);
      check("R10 freeze in wait idles", status[7:6], 2'd0);
      hwrite(5, 8'hAA);
      tick(3);
      check("R6 host write when idle", mdl[5], 8'hAA);
   endtask

   task automatic t_snap;
      int n0;
      int bad;
      wreg(2'd2, 8'h00);
      wreg(2'd0, 8'h83);
      n0 = wr_cnt;
      drive_field(1'b0, 8'h11, 1'b0);
      check("R4 snap ignores even start", wr_cnt - n0, 0);
      drive_field(1'b1, 8'h5A, 1'b0);
      check("R12 odd field status bits", mid_stat[5:2], 4'b1111);
      check("R11 first snap field not last", mid_stat[3], 1'b1);
      drive_field(1'b0, 8'h5A, 1'b0);
      check("R11 even snap field is last", mid_stat[3], 1'b0);
      check("R12 even field parity", mid_stat[2], 1'b0);
      check("R12 vertical blank reads low", status[5:4], 2'b00);
      check("R4 idle after snap", status[7:6], 2'd0);
      n0 = wr_cnt;
      drive_field(1'b1, 8'hC3, 1'b0);
      check("R4 no capture after snap", wr_cnt - n0, 0);
      bad = 0;
      for (int y = 0; y < FL; y++)
         for (int x = 0; x < LP; x++) begin
            if (mdl[y*2*LP + x] !== pat(8'h5A, 1'b1, y, x)) bad++;
            if (mdl[y*2*LP + LP + x] !== pat(8'h5A, 1'b0, y, x)) bad++;
         end
      check("R4 R9 snap frame contents", bad, 0);
   endtask

   task automatic t_grab;
      int n0;
      int bad;
      wreg(2'd1, 8'h00);
      wreg(2'd0, 8'h43);
      tick(DEPTH + 4);
      wreg(2'd2, 8'hF0);
      wreg(2'd0, 8'hC3);
      drive_field(1'b1, 8'h21, 1'b0);
      check("R8 grab running", status[7:6], 2'd3);
      drive_field(1'b0, 8'h21, 1'b0);
      check("R11 grab field not last", mid_stat[3], 1'b1);
      drive_field(1'b1, 8'h76, 1'b1);
      check("R11 last after freeze", mid_stat2[3], 1'b0);
      check("R8 stop at field end", status[7:6], 2'd0);
      n0 = wr_cnt;
      drive_field(1'b0, 8'h99, 1'b0);
      check("R8 no writes after stop", wr_cnt - n0, 0);
      bad = 0;
      for (int y = 0; y < FL; y++)
         for (int x = 0; x < LP; x++) begin
            if (mdl[y*2*LP + x] !== (pat(8'h76, 1'b1, y, x) & 8'h0F)) bad++;
            if (mdl[y*2*LP + LP + x] !== (pat(8'h21, 1'b0, y, x) & 8'h0F)) bad++;
         end
      check("R7 R8 grab contents with video mask", bad, 0);
   endtask

   task automatic t_hblank;
      vsync_blank = 1'b0; hsync_blank = 1'b1; field_odd = 1'b1;
      tick(4);
      check("R12 hblank reads low", status[5:4], 2'b01);
      check("R12 odd parity bit", status[2], 1'b1);
      hsync_blank = 1'b0;
      tick(4);
      check("R12 active reads high", status[5:4], 2'b11);
      vsync_blank = 1'b1; hsync_blank = 1'b1;
      tick(4);
   endtask

   initial begin
      for (int a = 0; a < DEPTH; a++) mdl[a] = 8'h00;
      tick(3);
      rst_n = 1'b1;
      t_reset();
      t_selects();
      t_clear();
      t_busy_ignore();
      t_snap();
      t_grab();
      t_hblank();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule